// File: doc/BRIEF.md
# Transmit Checksum Inserter

This block sits on an outgoing byte stream and fills in Internet-style ones-complement checksums before the packet leaves. It takes a side command with the first byte of each packet. The command carries a route tag and up to two independent checksum jobs. Each job has an enable bit, a UDP-style flag, a start offset, a byte length, an insertion offset and a 16-bit seed value. The seed lets the caller fold in a pseudo-header sum that was computed elsewhere. The block never looks inside the headers; every position it uses comes from the command.

The whole packet is written into an internal store while both sums are accumulated in the same pass. After the last byte arrives, the input is closed and the packet is streamed out with the captured route tag. The checksum bytes are substituted on the fly at the insertion offsets. If a range or an insertion field reaches past the end of the packet, the packet goes out unmodified with an error flag raised. Input is accepted again only once the final output byte has been taken.

Top module: `csum_inserter`

## Requirements
- R1: After reset, in_ready is 1 and out_valid is 0.
- R2: The block works store-and-forward. After the byte carrying in_last is accepted, out_valid is 1 and in_ready is 0 from the next cycle on. After the output byte carrying out_last is accepted, in_ready is 1 and out_valid is 0 from the next cycle on.
- R3: The output packet has the same length and byte order as the input packet. out_last marks its final byte. Every byte outside the insertion fields of the enabled jobs is passed unchanged.
- R4: The command is sampled together with the first byte of a packet. Job j (j = 0 or 1) takes its fields from bit slice [16j+15:16j] of cmd_start, cmd_len, cmd_ins and cmd_init, and from bit j of cmd_en and cmd_udp. A job's sum starts at its seed and adds 16-bit words with end-around carry. A byte at an even distance from the start offset is the high byte of its word, and a byte at an odd distance is the low byte. A trailing odd byte is therefore padded with a zero low byte.
- R5: An enabled job writes the ones complement of its final sum into the packet. The high byte goes at the insertion offset and the low byte at the insertion offset plus one.
- R6: The two bytes at a job's insertion offset and insertion offset plus one count as zero in that job's sum, whatever their input value.
- R7: When a job's UDP flag is 1 and its complemented sum is 0x0000, the value 0xFFFF is written instead. When the flag is 0, 0x0000 is written as is.
- R8: A job whose enable bit is 0 changes no byte and raises no error, whatever its other fields hold.
- R9: Both sums are taken over the bytes as they entered the block. Where the insertion fields of the two jobs overlap, job 1's bytes win.
- R10: Let L be the packet length in bytes. When any enabled job has start+length > L, or insertion offset+2 > L, out_err is 1 for the whole output packet and every byte is forwarded unmodified. Otherwise out_err is 0.
- R11: out_route shows the route tag sampled with the first byte, held for the whole output packet. While out_valid is 1 and out_ready is 0, out_valid, out_data and out_last hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_ready | output | 1 | Block can take an input byte |
| in_data | input | 8 | Input byte |
| in_last | input | 1 | Input byte is the final one of its packet |
| cmd_route | input | ROUTE_W | Route tag, sampled with the first byte |
| cmd_en | input | JOBS | Per-job enable |
| cmd_udp | input | JOBS | Per-job zero-result replacement flag |
| cmd_start | input | 16*JOBS | Per-job range start offset |
| cmd_len | input | 16*JOBS | Per-job range length in bytes |
| cmd_ins | input | 16*JOBS | Per-job insertion offset |
| cmd_init | input | 16*JOBS | Per-job seed value |
| out_valid | output | 1 | Output byte valid |
| out_ready | input | 1 | Downstream takes the output byte |
| out_data | output | 8 | Output byte |
| out_last | output | 1 | Output byte is the final one of its packet |
| out_route | output | ROUTE_W | Route tag of the packet being sent |
| out_err | output | 1 | Range error on the packet being sent |

## Verification
A corrupted accumulator or a wrong word-half choice stays hidden until the packet is read out. It then shows at the two insertion bytes only, so every sent byte is compared against a behavioural model. A phase register that goes wrong shows within one cycle of the last input or output handshake, as in_ready and out_valid both high or both low. A bad length or error evaluation shows as a wrong out_last position or an out_err that differs from the prediction on the first output byte.

// File: rtl/csum_ins_pkg.sv
package csum_ins_pkg;
   localparam int OFS_W = 16;

   typedef struct packed {
      logic             en;
      logic             udp;
      logic [OFS_W-1:0] start;
      logic [OFS_W-1:0] len;
      logic [OFS_W-1:0] ins;
      logic [OFS_W-1:0] init;
   } job_t;

   typedef enum logic [0:0] {
      ST_FILL = 1'b0,
      ST_SEND = 1'b1
   } phase_e;
endpackage

// File: rtl/csum_lane.sv
module csum_lane
   import csum_ins_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  job_t             job_in,
   input  logic             byte_en,
   input  logic [OFS_W-1:0] pos,
   input  logic [7:0]       byte_in,
   input  logic [OFS_W-1:0] pkt_len,
   output logic             en_q,
   output logic [OFS_W-1:0] ins_q,
   output logic [15:0]      csum,
   output logic             bad
);
   job_t             job_q;
   job_t             cur;
   logic [15:0]      acc_q;
   logic [15:0]      acc_base;
   logic [15:0]      addend;
   logic [16:0]      s17;
   logic [15:0]      acc_nxt;
   logic [OFS_W:0]   rng_end;
   logic             in_rng;
   logic             ins_hit;
   logic             take;
   logic             hi_half;
   logic [15:0]      cpl;
   logic [OFS_W:0]   end_q;
   logic [OFS_W:0]   ins_end_q;

   // the first byte of a packet uses the fresh command and seed
   assign cur      = load ? job_in : job_q;
   assign acc_base = load ? job_in.init : acc_q;

   always_comb begin
      rng_end = {1'b0, cur.start} + {1'b0, cur.len};
      in_rng  = (pos >= cur.start) && ({1'b0, pos} < rng_end);
      ins_hit = ({1'b0, pos} == {1'b0, cur.ins}) ||
                ({1'b0, pos} == ({1'b0, cur.ins} + 17'd1));
      take    = cur.en && in_rng && !ins_hit;
      hi_half = (pos[0] == cur.start[0]);
      addend  = take ? (hi_half ? {byte_in, 8'h00} : {8'h00, byte_in}) : 16'h0000;
      s17     = {1'b0, acc_base} + {1'b0, addend};
      acc_nxt = s17[15:0] + {15'd0, s17[16]};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q <= '0;
         job_q <= '0;
      end else if (byte_en) begin
         acc_q <= acc_nxt;
         if (load) job_q <= job_in;
      end
   end

   always_comb begin
      cpl       = ~acc_q;
      csum      = (job_q.udp && (cpl == 16'h0000)) ? 16'hFFFF : cpl;
      end_q     = {1'b0, job_q.start} + {1'b0, job_q.len};
      ins_end_q = {1'b0, job_q.ins} + 17'd2;
      bad       = job_q.en && ((end_q > {1'b0, pkt_len}) || (ins_end_q > {1'b0, pkt_len}));
   end

   assign en_q  = job_q.en;
   assign ins_q = job_q.ins;
endmodule

// File: rtl/pkt_store.sv
module pkt_store #(
   parameter int DEPTH = 2048,
   localparam int IW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          wr_en,
   input  logic [IW-1:0] wr_addr,
   input  logic [7:0]    wr_data,
   input  logic [IW-1:0] rd_addr,
   output logic [7:0]    rd_data
);
   logic [7:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_data;
   end

   assign rd_data = mem[rd_addr];
endmodule

// File: rtl/patch_mux.sv
module patch_mux
   import csum_ins_pkg::*;
#(
   parameter int JOBS = 2
) (
   input  logic [OFS_W-1:0]            pos,
   input  logic [7:0]                  raw,
   input  logic                        hold,
   input  logic [JOBS-1:0]             en,
   input  logic [JOBS-1:0][OFS_W-1:0]  ins,
   input  logic [JOBS-1:0][15:0]       sums,
   output logic [7:0]                  data_out
);
   // later jobs override earlier ones where fields overlap
   always_comb begin
      data_out = raw;
      if (!hold) begin
         for (int j = 0; j < JOBS; j++) begin
            if (en[j]) begin
               if ({1'b0, pos} == {1'b0, ins[j]})
                  data_out = sums[j][15:8];
               else if ({1'b0, pos} == ({1'b0, ins[j]} + 17'd1))
                  data_out = sums[j][7:0];
            end
         end
      end
   end
endmodule

// File: rtl/csum_inserter.sv
module csum_inserter
   import csum_ins_pkg::*;
#(
   parameter int DEPTH   = 2048,
   parameter int JOBS    = 2,
   parameter int ROUTE_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    in_valid,
   output logic                    in_ready,
   input  logic [7:0]              in_data,
   input  logic                    in_last,
   input  logic [ROUTE_W-1:0]      cmd_route,
   input  logic [JOBS-1:0]         cmd_en,
   input  logic [JOBS-1:0]         cmd_udp,
   input  logic [OFS_W*JOBS-1:0]   cmd_start,
   input  logic [OFS_W*JOBS-1:0]   cmd_len,
   input  logic [OFS_W*JOBS-1:0]   cmd_ins,
   input  logic [OFS_W*JOBS-1:0]   cmd_init,
   output logic                    out_valid,
   input  logic                    out_ready,
   output logic [7:0]              out_data,
   output logic                    out_last,
   output logic [ROUTE_W-1:0]      out_route,
   output logic                    out_err
);
   localparam int IW = $clog2(DEPTH);

   initial begin
      assert (DEPTH >= 2 && DEPTH <= 32768) else $fatal(1, "DEPTH out of range");
      assert (JOBS >= 1 && JOBS <= 4) else $fatal(1, "JOBS out of range");
      assert (ROUTE_W >= 1) else $fatal(1, "ROUTE_W out of range");
   end

   phase_e                      phase;
   logic [OFS_W-1:0]            wr_cnt;
   logic [OFS_W-1:0]            rd_cnt;
   logic [OFS_W-1:0]            pkt_len;
   logic [ROUTE_W-1:0]          route_q;
   logic                        acc_in;
   logic                        first;
   logic                        err;
   logic [7:0]                  raw_byte;
   job_t [JOBS-1:0]             cmd_jobs;
   logic [JOBS-1:0]             en_vec;
   logic [JOBS-1:0]             bad_vec;
   logic [JOBS-1:0][OFS_W-1:0]  ins_vec;
   logic [JOBS-1:0][15:0]       sum_vec;

   assign in_ready = (phase == ST_FILL);
   assign acc_in   = in_valid && in_ready;
   assign first    = (wr_cnt == '0);

   generate
      for (genvar j = 0; j < JOBS; j++) begin : g_lane
         assign cmd_jobs[j].en    = cmd_en[j];
         assign cmd_jobs[j].udp   = cmd_udp[j];
         assign cmd_jobs[j].start = cmd_start[j*OFS_W +: OFS_W];
         assign cmd_jobs[j].len   = cmd_len[j*OFS_W +: OFS_W];
         assign cmd_jobs[j].ins   = cmd_ins[j*OFS_W +: OFS_W];
         assign cmd_jobs[j].init  = cmd_init[j*OFS_W +: OFS_W];

         csum_lane u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .load    (acc_in && first),
            .job_in  (cmd_jobs[j]),
            .byte_en (acc_in),
            .pos     (wr_cnt),
            .byte_in (in_data),
            .pkt_len (pkt_len),
            .en_q    (en_vec[j]),
            .ins_q   (ins_vec[j]),
            .csum    (sum_vec[j]),
            .bad     (bad_vec[j])
         );
      end
   endgenerate

   assign err = |bad_vec;

   pkt_store #(.DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .wr_en   (acc_in),
      .wr_addr (wr_cnt[IW-1:0]),
      .wr_data (in_data),
      .rd_addr (rd_cnt[IW-1:0]),
      .rd_data (raw_byte)
   );

   patch_mux #(.JOBS(JOBS)) u_patch (
      .pos      (rd_cnt),
      .raw      (raw_byte),
      .hold     (err),
      .en       (en_vec),
      .ins      (ins_vec),
      .sums     (sum_vec),
      .data_out (out_data)
   );

   assign out_valid = (phase == ST_SEND);
   assign out_last  = out_valid && (rd_cnt == (pkt_len - 16'd1));
   assign out_route = route_q;
   assign out_err   = out_valid && err;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= ST_FILL;
         wr_cnt  <= '0;
         rd_cnt  <= '0;
         pkt_len <= '0;
         route_q <= '0;
      end else begin
         case (phase)
            ST_FILL: begin
               if (acc_in) begin
                  wr_cnt <= wr_cnt + 16'd1;
                  if (first) route_q <= cmd_route;
                  if (in_last) begin
                     pkt_len <= wr_cnt + 16'd1;
                     rd_cnt  <= '0;
                     phase   <= ST_SEND;
                  end
               end
            end
            ST_SEND: begin
               if (out_ready) begin
                  rd_cnt <= rd_cnt + 16'd1;
                  if (out_last) begin
                     wr_cnt <= '0;
                     phase  <= ST_FILL;
                  end
               end
            end
            default: phase <= ST_FILL;
         endcase
      end
   end
endmodule

// File: rtl/csum_inserter_chk.sv
module csum_inserter_chk #(
   parameter int ROUTE_W = 8
) (
   input logic               clk,
   input logic               rst_n,
   input logic               in_valid,
   input logic               in_ready,
   input logic               in_last,
   input logic               out_valid,
   input logic               out_ready,
   input logic               out_last,
   input logic [7:0]         out_data,
   input logic [ROUTE_W-1:0] out_route,
   input logic               out_err
);
   assert_exclusive_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_ready && out_valid));

   assert_send_after_last_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && in_last) |=> (out_valid && !in_ready));

   assert_reopen_after_send_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_ready && out_last) |=> (in_ready && !out_valid));

   assert_hold_under_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));

   assert_route_stable_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !(out_ready && out_last)) |=> $stable(out_route));

   assert_err_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !(out_ready && out_last)) |=> $stable(out_err));
endmodule

bind csum_inserter csum_inserter_chk #(.ROUTE_W(ROUTE_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .in_valid  (in_valid),
   .in_ready  (in_ready),
   .in_last   (in_last),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_last  (out_last),
   .out_data  (out_data),
   .out_route (out_route),
   .out_err   (out_err)
);

// File: tb/test_csum_inserter.sv
module test_csum_inserter;
   localparam int JOBS = 2;
   localparam int RW   = 8;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic             rst_n;
   logic             in_valid, in_ready, in_last;
   logic [7:0]       in_data;
   logic [RW-1:0]    cmd_route;
   logic [JOBS-1:0]  cmd_en, cmd_udp;
   logic [31:0]      cmd_start, cmd_len, cmd_ins, cmd_init;
   logic             out_valid, out_ready, out_last, out_err;
   logic [7:0]       out_data;
   logic [RW-1:0]    out_route;

   csum_inserter #(.DEPTH(2048), .JOBS(JOBS), .ROUTE_W(RW)) i_csum_inserter (
      .clk(clk), .rst_n(rst_n),
      .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data), .in_last(in_last),
      .cmd_route(cmd_route), .cmd_en(cmd_en), .cmd_udp(cmd_udp),
      .cmd_start(cmd_start), .cmd_len(cmd_len), .cmd_ins(cmd_ins), .cmd_init(cmd_init),
      .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
      .out_last(out_last), .out_route(out_route), .out_err(out_err)
   );

   int vectors = 0;
   int miscompares = 0;
   int cycles = 0;
   bit done = 0;

   logic [7:0] pb  [0:511];
   logic [7:0] ex  [0:511];
   logic [7:0] got [0:511];
   bit j_en [2];
   bit j_udp [2];
   int j_start [2], j_len [2], j_ins [2], j_init [2];

   task automatic check(input bit ok, input string req, input string what,
                        input int act, input int exp);
      vectors++;
      if (!ok) begin
         miscompares++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic summary();
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles > 150000 && !done) begin
         done = 1;
         vectors++;
         miscompares++;
         $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
         summary();
      end
   end

   // behavioural model: returns expected error flag, fills ex[]
   function automatic bit model(input int L);
      bit e = 0;
      for (int i = 0; i < L; i++) ex[i] = pb[i];
      for (int j = 0; j < 2; j++)
         if (j_en[j] && ((j_start[j] + j_len[j] > L) || (j_ins[j] + 2 > L))) e = 1;
      if (!e) begin
         for (int j = 0; j < 2; j++) begin
            int s;
            int cs;
            if (!j_en[j]) continue;
            s = j_init[j];
            for (int p = j_start[j]; p < j_start[j] + j_len[j]; p++) begin
               if (p == j_ins[j] || p == j_ins[j] + 1) continue;
               s += (((p - j_start[j]) % 2) == 0) ? (int'(pb[p]) << 8) : int'(pb[p]);
               if (s > 32'hFFFF) s = (s & 32'hFFFF) + 1;
            end
            cs = (~s) & 32'hFFFF;
            if (j_udp[j] && cs == 0) cs = 32'hFFFF;
            ex[j_ins[j]]     = cs[15:8];
            ex[j_ins[j] + 1] = cs[7:0];
         end
      end
      return e;
   endfunction

   task automatic run_pkt(input int L, input int route, input int stall, input string tag);
      bit e_err;
      int k;
      int cyc;
      e_err = model(L);
      cmd_route = route[RW-1:0];
      for (int j = 0; j < 2; j++) begin
         cmd_en[j]            = j_en[j];
         cmd_udp[j]           = j_udp[j];
         cmd_start[j*16 +: 16] = j_start[j][15:0];
         cmd_len[j*16 +: 16]   = j_len[j][15:0];
         cmd_ins[j*16 +: 16]   = j_ins[j][15:0];
         cmd_init[j*16 +: 16]  = j_init[j][15:0];
      end
      for (int i = 0; i < L; i++) begin
         @(negedge clk);
         in_valid = 1'b1;
         in_data  = pb[i];
         in_last  = (i == L - 1);
         if (!in_ready) check(0, "R2", "in_ready during fill", 0, 1);
         if (out_valid) check(0, "R2", "out_valid during fill", 1, 0);
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_last  = 1'b0;
      check(out_valid == 1'b1 && in_ready == 1'b0, "R2", "out_valid,in_ready after last",
            {out_valid, in_ready}, 2'b10);
      k = 0;
      cyc = 0;
      while (k < L) begin
         out_ready = (stall == 0) ? 1'b1 : ((cyc % stall) != 0);
         cyc++;
         #1;
         if (!out_valid) begin
            check(0, "R2", "out_valid mid packet", 0, 1);
            k = L;
         end else if (out_ready) begin
            got[k] = out_data;
            check(out_data == ex[k], tag, $sformatf("byte %0d", k), out_data, ex[k]);
            check(out_last == (k == L - 1), "R3", $sformatf("out_last at %0d", k),
                  out_last, (k == L - 1));
            check(out_route == route[RW-1:0], "R11", "out_route", out_route, route);
            check(out_err == e_err, "R10", "out_err", out_err, e_err);
            k++;
         end
         @(negedge clk);
      end
      out_ready = 1'b0;
      check(in_ready == 1'b1 && out_valid == 1'b0, "R2", "in_ready,out_valid after send",
            {in_ready, out_valid}, 2'b10);
   endtask

   task automatic set_job(input int j, input bit en, input bit udp, input int st,
                          input int ln, input int ins, input int init);
      j_en[j] = en; j_udp[j] = udp; j_start[j] = st;
      j_len[j] = ln; j_ins[j] = ins; j_init[j] = init;
   endtask

   task automatic fill_pattern(input int L, input int seed);
      for (int i = 0; i < L; i++) pb[i] = 8'((i * 37 + seed) & 255);
   endtask

   initial begin
      rst_n = 1'b0; in_valid = 1'b0; in_last = 1'b0; in_data = '0;
      out_ready = 1'b0; cmd_route = '0; cmd_en = '0; cmd_udp = '0;
      cmd_start = '0; cmd_len = '0; cmd_ins = '0; cmd_init = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
      check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);

      // R4 R5 R6: known IPv4 header, field preloaded with junk
      begin
         logic [7:0] hdr [20] = '{8'h45,8'h00,8'h00,8'h73,8'h00,8'h00,8'h40,8'h00,8'h40,8'h11,
                                  8'h12,8'h34,8'hc0,8'ha8,8'h00,8'h01,8'hc0,8'ha8,8'h00,8'hc7};
         for (int i = 0; i < 20; i++) pb[i] = hdr[i];
         for (int i = 20; i < 28; i++) pb[i] = 8'(i);
      end
      set_job(0, 1, 0, 0, 20, 10, 0);
      set_job(1, 0, 0, 0, 0, 0, 0);
      run_pkt(28, 8'h3C, 0, "R4");
      check(got[10] == 8'hB8, "R5", "ip csum high", got[10], 8'hB8);
      check(got[11] == 8'h61, "R6", "ip csum low", got[11], 8'h61);

      // R4 R9: odd range, seed, two jobs, stalls
      fill_pattern(37, 5);
      set_job(0, 1, 0, 0, 20, 10, 16'h1234);
      set_job(1, 1, 1, 20, 17, 26, 16'hF00D);
      run_pkt(37, 8'h51, 3, "R4");

      // R7: zero result replaced only for the UDP-flagged job
      for (int i = 0; i < 8; i++) pb[i] = 8'h00;
      pb[0] = 8'hFF; pb[1] = 8'hFF;
      set_job(0, 1, 0, 0, 2, 2, 0);
      set_job(1, 1, 1, 0, 2, 4, 0);
      run_pkt(8, 8'h07, 0, "R7");
      check(got[2] == 8'h00 && got[3] == 8'h00, "R7", "plain zero", {got[2], got[3]}, 0);
      check(got[4] == 8'hFF && got[5] == 8'hFF, "R7", "udp zero", {got[4], got[5]}, 16'hFFFF);

      // R8: disabled jobs with wild fields
      fill_pattern(30, 77);
      set_job(0, 0, 1, 1000, 5000, 40000, 16'hAAAA);
      set_job(1, 0, 0, 3, 4, 2, 16'h5555);
      run_pkt(30, 8'hA2, 2, "R8");

      // R10: range past end
      fill_pattern(30, 9);
      set_job(0, 1, 0, 4, 100, 6, 0);
      set_job(1, 1, 0, 0, 10, 12, 0);
      run_pkt(30, 8'h11, 0, "R10");

      // R10: insertion field straddles end
      fill_pattern(30, 19);
      set_job(0, 1, 0, 0, 10, 4, 0);
      set_job(1, 1, 0, 0, 30, 29, 0);
      run_pkt(30, 8'h12, 4, "R10");

      // R9: overlapping insertion fields, job 1 wins
      fill_pattern(40, 101);
      set_job(0, 1, 0, 0, 40, 8, 16'h0101);
      set_job(1, 1, 0, 10, 21, 8, 0);
      run_pkt(40, 8'h99, 0, "R9");

      // R3: long packet under back-pressure
      fill_pattern(200, 33);
      set_job(0, 1, 0, 14, 20, 24, 0);
      set_job(1, 1, 1, 34, 166, 40, 16'h2345);
      run_pkt(200, 8'hE4, 5, "R3");

      // R3: single byte packet
      pb[0] = 8'h5A;
      set_job(0, 0, 0, 0, 0, 0, 0);
      set_job(1, 0, 0, 0, 0, 0, 0);
      run_pkt(1, 8'h01, 0, "R3");

      done = 1;
      summary();
   end
endmodule